// File: doc/BRIEF.md
# Single-Line Evicted-Line Drain Buffer

This block sits beside an operand cache that runs in write-back mode. When the cache replaces a dirty line, its controller moves the whole line into this buffer in a single transfer: four 32-bit longwords, the line address (address bits 31 to 4) and the two-bit longword offset where the drain should begin. The cache then fetches the replacement line. The buffer keeps the victim meanwhile and does not touch the cache arrays, so the cache stays usable.

After the controller signals that the fill has finished, the buffer writes the four longwords to external memory over a simple valid/acknowledge longword write port. The order wraps around from the captured offset: a start at offset 1 gives byte offsets 0x4, 0x8, 0xC, 0x0. The top three bits of every address sent out are forced to zero. A busy flag stays high from the load until the last longword is acknowledged. The controller keeps its next eviction back until the buffer reports empty.

Top module: `line_drain_buffer`

## Requirements
- R1: After reset, `busy` is 0, `loadReady` is 1 and `memWrValid` is 0.
- R2: A load is accepted only on a clock edge where `loadValid` and `loadReady` are both 1. A `loadValid` while busy is ignored and the line already held drains unchanged.
- R3: `memWrValid` stays 0 from the load until the first clock edge after the load where `fillDone` is 1. A `fillDone` seen while empty is ignored. `memWrValid` rises in the cycle after that `fillDone` edge.
- R4: The four beats use longword offsets start, start+1, start+2, start+3, taken modulo 4, where start is `loadStartOfs` captured at load.
- R5: Each beat address is {3'b000, line address bits 28..4, the beat's offset, 2'b00}, where line address bit k sits at `loadLineAddr[k-4]`.
- R6: Each beat's data is longword k of the captured line, which is `loadData[32k+31:32k]` for offset k.
- R7: While `memWrValid` is 1 and `memWrAck` is 0, address and data hold stable and `memWrValid` stays 1.
- R8: `busy` is 1 from the edge after the load until the edge that takes the fourth acknowledge. After that edge `busy` is 0 and `loadReady` is 1. `loadReady` always equals the inverse of `busy`.
- R9: `memWrAck` has no effect while `memWrValid` is 0. It neither advances nor ends the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | Controller offers an evicted line |
| loadLineAddr | input | 28 | Line address, bits 31..4 |
| loadStartOfs | input | 2 | Longword offset where the drain begins |
| loadData | input | 128 | Line data, longword k in bits 32k+31..32k |
| loadReady | output | 1 | Buffer empty, a load will be accepted |
| fillDone | input | 1 | Pending line fill has finished, drain may start |
| busy | output | 1 | Buffer holds a line not yet fully written |
| memWrValid | output | 1 | A longword write is presented |
| memWrAddr | output | 32 | Byte address of the presented longword |
| memWrData | output | 32 | Presented longword |
| memWrAck | input | 1 | Memory accepts the presented longword |

## Verification
A wrong beat counter or start offset shows up at once on `memWrAddr` bits 3..2 and on `memWrData` of the first or the next beat. A state register that leaves the wait-for-fill phase early shows a `memWrValid` one cycle after the load. One that counts acknowledges badly ends the drain a beat early or late, so `busy` falls on the wrong edge. That becomes visible within one cycle of the fourth acknowledge. A corrupted capture, such as a load taken while busy, shows up as a wrong address or data word on the next beat presented.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // store a new line and reset the beat counter
    logic advance;   // current beat acknowledged, move to next offset
  } ldbStrobe_t;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } ldbState_t;

endpackage

// File: rtl/ldb_datapath.sv
module ldb_datapath
  import ldb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int ZERO_TOP = 3,
  localparam int OFS_W   = $clog2(WORDS),
  localparam int BYTE_W  = $clog2(WORD_W / 8),
  localparam int LINE_W  = ADDR_W - OFS_W - BYTE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ldbStrobe_t              strobe,
  input  logic [LINE_W-1:0]       loadLineAddr,
  input  logic [OFS_W-1:0]        loadStartOfs,
  input  logic [WORDS*WORD_W-1:0] loadData,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [WORD_W-1:0]       memWrData,
  output logic                    lastBeat
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = {ADDR_W{1'b1}} >> ZERO_TOP;
  localparam logic [OFS_W-1:0]  LAST_CNT  = OFS_W'(WORDS - 1);

  logic [LINE_W-1:0] lineReg;
  logic [OFS_W-1:0]  startReg;
  logic [OFS_W-1:0]  beatCnt;
  logic [OFS_W-1:0]  curOfs;
  logic [WORD_W-1:0] wordReg [WORDS];
  logic [ADDR_W-1:0] rawAddr;

  // Line address, start offset and beat counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg  <= '0;
      startReg <= '0;
      beatCnt  <= '0;
    end else if (strobe.capture) begin
      lineReg  <= loadLineAddr;
      startReg <= loadStartOfs;
      beatCnt  <= '0;
    end else if (strobe.advance) begin
      beatCnt  <= beatCnt + OFS_W'(1);
    end
  end

  // One storage register per longword
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordReg[w] <= '0;
      end else if (strobe.capture) begin
        wordReg[w] <= loadData[w*WORD_W +: WORD_W];
      end
    end
  end

  // Wrap-around offset: modulo arithmetic by the counter width
  always_comb begin
    curOfs    = startReg + beatCnt;
    rawAddr   = {lineReg, curOfs, BYTE_W'(0)};
    memWrAddr = rawAddr & KEEP_MASK;
    memWrData = wordReg[curOfs];
    lastBeat  = (beatCnt == LAST_CNT);
  end

  // R4
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !lastBeat |=> curOfs == $past(curOfs) + OFS_W'(1));

endmodule

// File: rtl/ldb_control.sv
module ldb_control
  import ldb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadValid,
  input  logic       fillDone,
  input  logic       memWrAck,
  input  logic       lastBeat,
  output ldbStrobe_t strobe,
  output logic       busy,
  output logic       loadReady,
  output logic       memWrValid
);

  ldbState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.capture = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_EMPTY: begin
        if (loadValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (fillDone) stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (memWrAck) begin
          strobe.advance = 1'b1;
          if (lastBeat) stateNext = ST_EMPTY;
        end
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_EMPTY;
    else       state <= stateNext;
  end

  always_comb begin
    busy       = (state != ST_EMPTY);
    loadReady  = (state == ST_EMPTY);
    memWrValid = (state == ST_DRAIN);
  end

  // R3
  no_early_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT && !fillDone |=> !memWrValid);

  // R8
  last_ack_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && memWrAck && lastBeat |=> !busy && loadReady);

  // R9
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !loadValid |=> !busy);

endmodule

// File: rtl/line_drain_buffer.sv
module line_drain_buffer
  import ldb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int ZERO_TOP = 3,
  localparam int OFS_W   = $clog2(WORDS),
  localparam int BYTE_W  = $clog2(WORD_W / 8),
  localparam int LINE_W  = ADDR_W - OFS_W - BYTE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadValid,
  input  logic [LINE_W-1:0]       loadLineAddr,
  input  logic [OFS_W-1:0]        loadStartOfs,
  input  logic [WORDS*WORD_W-1:0] loadData,
  output logic                    loadReady,
  input  logic                    fillDone,
  output logic                    busy,
  output logic                    memWrValid,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [WORD_W-1:0]       memWrData,
  input  logic                    memWrAck
);

  ldbStrobe_t strobe;
  logic       lastBeat;

  ldb_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .loadValid  (loadValid),
    .fillDone   (fillDone),
    .memWrAck   (memWrAck),
    .lastBeat   (lastBeat),
    .strobe     (strobe),
    .busy       (busy),
    .loadReady  (loadReady),
    .memWrValid (memWrValid)
  );

  ldb_datapath #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .WORDS    (WORDS),
    .ZERO_TOP (ZERO_TOP)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .loadLineAddr (loadLineAddr),
    .loadStartOfs (loadStartOfs),
    .loadData     (loadData),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData),
    .lastBeat     (lastBeat)
  );

  // R7
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid && !memWrAck |=> memWrValid && $stable(memWrAddr) && $stable(memWrData));

  // R5
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> memWrAddr[ADDR_W-1 -: ZERO_TOP] == '0 && memWrAddr[BYTE_W-1:0] == '0);

  // R2
  load_goes_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && loadReady |=> busy && !memWrValid);

  // R8
  ready_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadReady != busy);

endmodule

// File: tb/line_drain_buffer_tb.sv
module line_drain_buffer_tb;

  logic         clk = 1'b0;
  logic         rstN;
  logic         loadValid;
  logic [27:0]  loadLineAddr;
  logic [1:0]   loadStartOfs;
  logic [127:0] loadData;
  logic         loadReady;
  logic         fillDone;
  logic         busy;
  logic         memWrValid;
  logic [31:0]  memWrAddr;
  logic [31:0]  memWrData;
  logic         memWrAck;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  line_drain_buffer u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .loadValid    (loadValid),
    .loadLineAddr (loadLineAddr),
    .loadStartOfs (loadStartOfs),
    .loadData     (loadData),
    .loadReady    (loadReady),
    .fillDone     (fillDone),
    .busy         (busy),
    .memWrValid   (memWrValid),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData),
    .memWrAck     (memWrAck)
  );

  function automatic logic [31:0] expAddr(logic [27:0] la, logic [1:0] st, int beat);
    logic [1:0] o;
    o = st + 2'(beat);
    return {3'b000, la[24:0], o, 2'b00};
  endfunction

  function automatic logic [31:0] expData(logic [127:0] d, logic [1:0] st, int beat);
    logic [1:0] o;
    o = st + 2'(beat);
    return d[32*o +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full line: load, wait for fill, drain with random stalls
  task automatic runLine(logic [27:0] la, logic [1:0] st, logic [127:0] d);
    @(negedge clk);
    #1 chk("R8 ready before load", {31'd0, loadReady}, 32'd1);
    loadValid = 1'b1; loadLineAddr = la; loadStartOfs = st; loadData = d;
    @(negedge clk);
    loadValid = 1'b0;
    #1 chk("R8 busy after load", {31'd0, busy}, 32'd1);
    chk("R3 no write before fill", {31'd0, memWrValid}, 32'd0);
    for (int i = 0; i < int'($urandom % 4); i++) begin
      @(negedge clk);
      memWrAck  = $urandom % 2;
      loadValid = 1'b1;
      loadLineAddr = ~la; loadStartOfs = st + 2'd1; loadData = ~d;
      #1 chk("R2 ready low while held", {31'd0, loadReady}, 32'd0);
      chk("R3 idle until fill", {31'd0, memWrValid}, 32'd0);
    end
    @(negedge clk);
    loadValid = 1'b0; memWrAck = 1'b0; fillDone = 1'b1;
    #1 chk("R3 no write on fill cycle", {31'd0, memWrValid}, 32'd0);
    @(negedge clk);
    fillDone = 1'b0;
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < int'($urandom % 3); w++) begin
        #1 chk("R7 valid held", {31'd0, memWrValid}, 32'd1);
        chk("R5 stalled address", memWrAddr, expAddr(la, st, b));
        chk("R6 stalled data", memWrData, expData(d, st, b));
        @(negedge clk);
      end
      memWrAck = 1'b1;
      #1 chk("R3 valid during drain", {31'd0, memWrValid}, 32'd1);
      chk("R4 R5 beat address", memWrAddr, expAddr(la, st, b));
      chk("R6 beat data", memWrData, expData(d, st, b));
      if (b < 3) chk("R8 busy mid drain", {31'd0, busy}, 32'd1);
      @(negedge clk);
      memWrAck = 1'b0;
    end
    #1 chk("R8 free after last ack", {30'd0, busy, loadReady}, 32'd1);
    chk("R8 no write after drain", {31'd0, memWrValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; loadValid = 1'b0; loadLineAddr = '0; loadStartOfs = '0;
    loadData = '0; fillDone = 1'b0; memWrAck = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset ready", {31'd0, loadReady}, 32'd1);
    chk("R1 reset valid", {31'd0, memWrValid}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R9 and R3: ack and fill while empty have no effect
    @(negedge clk);
    memWrAck = 1'b1; fillDone = 1'b1;
    @(negedge clk);
    memWrAck = 1'b0; fillDone = 1'b0;
    #1 chk("R9 ack while empty", {30'd0, busy, memWrValid}, 32'd0);
    chk("R3 fill while empty", {31'd0, loadReady}, 32'd1);

    // Directed: every start offset, all-ones line address for the mask
    for (int s = 0; s < 4; s++)
      runLine(28'hFFF_FFFF, 2'(s), {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000});
    runLine(28'h000_0000, 2'd3, 128'h0);

    // Random lines
    for (int n = 0; n < 40; n++)
      runLine(28'($urandom), 2'($urandom),
              {$urandom, $urandom, $urandom, $urandom});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule